// File: doc/BRIEF.md
# Sticky Error Status Reporter

This block keeps a 16-bit error status word for a memory-controller host bridge and turns new error conditions into outgoing requests. Four hardware event lines (a run-behind queue that has filled, a request pushed into that run-behind queue, a locked access that missed DRAM, and a DRAM throttling episode) each latch a sticky flag. A thermal trip input latches a fifth flag, but only when the trip is actually delivered on one of three interrupt routes.

Software reads the word through a read-data port and clears flags by writing ones. The block raises a one-cycle error-message request when a flag goes from 0 to 1 and that source is enabled. A flag that is already set suppresses further requests from its source until software clears it. The thermal route enables must select exactly one destination. Any other legal-looking setting with more than one route is reported as a configuration error, and the trip is dropped.

Top module: `errstat_reporter`

## Requirements
- R1: After a cycle with `por_rst` high, `csr_rdata` reads 0000h and `err_msg_req`, `smi_req` and `sci_req` are low.
- R2: Only bits 14, 13, 11, 9 and 7 of `csr_rdata` can be 1. Every other bit reads 0, including after a write of FFFFh.
- R3: A `csr_wr` cycle clears every flag whose `csr_wdata` bit is 1 at the next edge. Flags whose `csr_wdata` bit is 0 keep their value.
- R4: `hw_evt[0]`, `hw_evt[1]`, `hw_evt[2]` and `hw_evt[3]` set bits 14, 13, 9 and 7 at the next edge, whatever the enables are.
- R5: When `hw_evt[i]` is high, its flag is clear, `err_src_en[i]` is 1 and `err_global_en` is 1, `err_msg_req` is high for the one cycle after that edge. This is the same cycle in which the flag first reads 1.
- R6: An event on a flag that already reads 1 produces no request.
- R7: Several flags rising at the same edge produce a single one-cycle request.
- R8: A trip with exactly one route enabled is delivered at the next edge, and bit 11 sets. The SMI route pulses `smi_req`, the SCI route pulses `sci_req`, and the SERR route pulses `err_msg_req`. The SERR route is delivered only when `err_global_en` is 1. A trip that is not delivered leaves bit 11 clear.
- R9: `therm_cfg_err` is high whenever two or more route enables are 1. A trip under that setting sets no flag and raises no request.
- R10: `warm_rst` leaves all flags unchanged and forces the three request outputs low in the following cycle.
- R11: When an event and a write-1 clear hit the same flag at the same edge, the flag ends up set. If the flag was clear, the enabled request still fires.
- R12: While bit 11 reads 1, further trips raise no request on any route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears flags and outputs |
| warm_rst | input | 1 | Warm reset, synchronous, active high; clears request outputs only |
| hw_evt | input | 4 | Error events: [0] queue full, [1] queue push, [2] lock miss, [3] throttle |
| therm_trip | input | 1 | Thermal trip event |
| err_global_en | input | 1 | Global error-message enable |
| err_src_en | input | 4 | Per-source message enables, same order as `hw_evt` |
| therm_en_smi | input | 1 | Route thermal trips to the SMI request |
| therm_en_sci | input | 1 | Route thermal trips to the SCI request |
| therm_en_serr | input | 1 | Route thermal trips to the error-message request |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 16 | Write data; ones clear flags |
| csr_rdata | output | 16 | Current status word |
| err_msg_req | output | 1 | One-cycle error-message request |
| smi_req | output | 1 | One-cycle SMI request for a thermal trip |
| sci_req | output | 1 | One-cycle SCI request for a thermal trip |
| therm_cfg_err | output | 1 | More than one thermal route enabled |

## Verification
The bench aims at the edge cases of the rising-edge rule. A repeat event on a flag that is already set must stay silent; a design that requests on the level would send a message every cycle the event stays high. Events that coincide with a write-1 clear must leave the flag set; a design where the clear wins would lose both the flag and its request. Several flags rising together must yield one pulse, not one per flag. The thermal flag must stay clear when no route, or an illegal pair of routes, is enabled; a design that latches on the raw trip would show bit 11 with nothing sent. Warm reset is pulsed with flags set to catch a design that treats it like power-on reset.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int REG_W = 16;
    localparam int NGEN  = 4;            // event-driven flags
    localparam int NFLAG = NGEN + 1;     // plus the thermal flag
    localparam int THERM_IDX = NGEN;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_SMI  = 2'd1,
        RT_SCI  = 2'd2,
        RT_SERR = 2'd3
    } therm_route_e;

    typedef struct packed {
        logic smi;
        logic sci;
        logic serr;
    } route_en_t;

    // Bit position of each flag inside the status word.
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 14;
            1:       return 13;
            2:       return 9;
            3:       return 7;
            default: return 11;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] flag_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NFLAG; i++) m[flag_pos(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] route_count(input route_en_t en);
        return {1'b0, en.smi} + {1'b0, en.sci} + {1'b0, en.serr};
    endfunction

endpackage

// File: rtl/errstat_flag_bank.sv
module errstat_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] rise_o
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_cell
            logic q;
            always_ff @(posedge clk) begin
                if (por_rst)
                    q <= 1'b0;
                else
                    q <= set_i[g] | (q & ~clr_i[g]);   // set beats clear
            end
            assign flag_o[g] = q;
            assign rise_o[g] = set_i[g] & ~q;
        end
    endgenerate

endmodule

// File: rtl/errstat_therm_router.sv
module errstat_therm_router
    import errstat_pkg::*;
(
    input  logic         trip_i,
    input  route_en_t    en_i,
    input  logic         global_en_i,
    input  logic         flag_i,
    output logic         dispatch_o,
    output therm_route_e route_o,
    output logic         cfg_err_o
);

    logic [1:0] n_routes;

    always_comb begin
        n_routes  = route_count(en_i);
        cfg_err_o = (n_routes > 2'd1);
        if (n_routes != 2'd1)
            route_o = RT_NONE;
        else if (en_i.smi)
            route_o = RT_SMI;
        else if (en_i.sci)
            route_o = RT_SCI;
        else
            route_o = RT_SERR;
        dispatch_o = trip_i && !flag_i && (route_o != RT_NONE)
                  && ((route_o != RT_SERR) || global_en_i);
    end

endmodule

// File: rtl/errstat_msg_gen.sv
module errstat_msg_gen #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic         warm_rst,
    input  logic [W-1:0] fire_i,
    output logic [W-1:0] pulse_o
);

    always_ff @(posedge clk) begin
        if (por_rst || warm_rst)
            pulse_o <= '0;
        else
            pulse_o <= fire_i;
    end

endmodule

// File: rtl/errstat_reporter.sv
module errstat_reporter
    import errstat_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             warm_rst,
    input  logic [NGEN-1:0]  hw_evt,
    input  logic             therm_trip,
    input  logic             err_global_en,
    input  logic [NGEN-1:0]  err_src_en,
    input  logic             therm_en_smi,
    input  logic             therm_en_sci,
    input  logic             therm_en_serr,
    input  logic             csr_wr,
    input  logic [REG_W-1:0] csr_wdata,
    output logic [REG_W-1:0] csr_rdata,
    output logic             err_msg_req,
    output logic             smi_req,
    output logic             sci_req,
    output logic             therm_cfg_err
);

    localparam int PW = 3;

    logic [NFLAG-1:0] set_v, clr_v, flag_v, rise_v;
    logic             dispatch;
    therm_route_e     route;
    route_en_t        route_en;
    logic [PW-1:0]    fire_v, pulse_v;

    assign route_en = '{smi: therm_en_smi, sci: therm_en_sci, serr: therm_en_serr};

    errstat_therm_router u_router (
        .trip_i      (therm_trip),
        .en_i        (route_en),
        .global_en_i (err_global_en),
        .flag_i      (flag_v[THERM_IDX]),
        .dispatch_o  (dispatch),
        .route_o     (route),
        .cfg_err_o   (therm_cfg_err)
    );

    assign set_v = {dispatch, hw_evt};

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_map
            localparam int P = flag_pos(g);
            assign clr_v[g] = csr_wr & csr_wdata[P];
        end
    endgenerate

    errstat_flag_bank #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .por_rst (por_rst),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .flag_o  (flag_v),
        .rise_o  (rise_v)
    );

    always_comb begin
        fire_v[0] = (err_global_en && |(rise_v[NGEN-1:0] & err_src_en))
                 || (rise_v[THERM_IDX] && route == RT_SERR);
        fire_v[1] = rise_v[THERM_IDX] && route == RT_SMI;
        fire_v[2] = rise_v[THERM_IDX] && route == RT_SCI;
    end

    errstat_msg_gen #(.W(PW)) u_msg (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .fire_i   (fire_v),
        .pulse_o  (pulse_v)
    );

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NFLAG; i++) csr_rdata[flag_pos(i)] = flag_v[i];
    end

    assign err_msg_req = pulse_v[0];
    assign smi_req     = pulse_v[1];
    assign sci_req     = pulse_v[2];

endmodule

// File: rtl/errstat_reporter_chk.sv
module errstat_reporter_chk
    import errstat_pkg::*;
(
    input logic             clk,
    input logic             por_rst,
    input logic             warm_rst,
    input logic [NGEN-1:0]  hw_evt,
    input logic             therm_trip,
    input logic             err_global_en,
    input logic             therm_cfg_err,
    input logic             csr_wr,
    input logic [REG_W-1:0] csr_wdata,
    input logic [REG_W-1:0] csr_rdata,
    input logic             err_msg_req,
    input logic             smi_req,
    input logic             sci_req
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
        (csr_rdata & ~flag_mask()) == '0);

    // R5
    msg_needs_global_chk: assert property (@(posedge clk) disable iff (por_rst)
        err_msg_req && !smi_req && !sci_req && !$past(warm_rst) |-> $past(err_global_en));

    // R11
    collide_set_wins_chk: assert property (@(posedge clk) disable iff (por_rst)
        hw_evt[0] && csr_wr && csr_wdata[14] |=> csr_rdata[14]);

    // R9
    cfg_err_blocks_chk: assert property (@(posedge clk) disable iff (por_rst)
        therm_trip && therm_cfg_err && !csr_rdata[11] |=> !csr_rdata[11] && !smi_req && !sci_req);

    // R8
    therm_flag_sent_chk: assert property (@(posedge clk) disable iff (por_rst)
        $rose(csr_rdata[11]) && !$past(warm_rst) |-> (smi_req || sci_req || err_msg_req));

    // R8
    one_route_chk: assert property (@(posedge clk) disable iff (por_rst)
        $onehot0({smi_req, sci_req}));

    // R3 / R10: flags only fall after a write-1 clear
    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_sticky
            localparam int P = flag_pos(g);
            sticky_fall_chk: assert property (@(posedge clk) disable iff (por_rst)
                $fell(csr_rdata[P]) |-> $past(csr_wr && csr_wdata[P]));
        end
    endgenerate

endmodule

bind errstat_reporter errstat_reporter_chk u_chk (
    .clk           (clk),
    .por_rst       (por_rst),
    .warm_rst      (warm_rst),
    .hw_evt        (hw_evt),
    .therm_trip    (therm_trip),
    .err_global_en (err_global_en),
    .therm_cfg_err (therm_cfg_err),
    .csr_wr        (csr_wr),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .err_msg_req   (err_msg_req),
    .smi_req       (smi_req),
    .sci_req       (sci_req)
);

// File: tb/errstat_reporter_tb_top.sv
module errstat_reporter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 50000;

    logic        clk = 1'b0;
    logic        por_rst, warm_rst, therm_trip, err_global_en;
    logic [3:0]  hw_evt, err_src_en;
    logic        therm_en_smi, therm_en_sci, therm_en_serr;
    logic        csr_wr;
    logic [15:0] csr_wdata, csr_rdata;
    logic        err_msg_req, smi_req, sci_req, therm_cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference state
    bit [15:0] m_reg;
    bit m_msg, m_smi, m_sci;
    int pos[4] = '{14, 13, 9, 7};

    always #(CLK_PERIOD/2) clk = ~clk;

    errstat_reporter dut_i (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .hw_evt(hw_evt),
        .therm_trip(therm_trip), .err_global_en(err_global_en), .err_src_en(err_src_en),
        .therm_en_smi(therm_en_smi), .therm_en_sci(therm_en_sci), .therm_en_serr(therm_en_serr),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .err_msg_req(err_msg_req), .smi_req(smi_req), .sci_req(sci_req),
        .therm_cfg_err(therm_cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int n_routes();
        return int'(therm_en_smi) + int'(therm_en_sci) + int'(therm_en_serr);
    endfunction

    task automatic model_step();
        bit [15:0] nxt;
        bit fire, smi, sci;
        fire = 0; smi = 0; sci = 0;
        if (por_rst) begin
            m_reg = '0; m_msg = 0; m_smi = 0; m_sci = 0;
            return;
        end
        nxt = m_reg;
        if (csr_wr) nxt = nxt & ~csr_wdata;
        for (int i = 0; i < 4; i++) begin
            if (hw_evt[i]) begin
                if (!m_reg[pos[i]] && err_global_en && err_src_en[i]) fire = 1;
                nxt[pos[i]] = 1;
            end
        end
        if (therm_trip && n_routes() == 1 && !m_reg[11]) begin
            if (therm_en_smi) begin smi = 1; nxt[11] = 1; end
            else if (therm_en_sci) begin sci = 1; nxt[11] = 1; end
            else if (err_global_en) begin fire = 1; nxt[11] = 1; end
        end
        m_reg = nxt;
        if (warm_rst) begin m_msg = 0; m_smi = 0; m_sci = 0; end
        else begin m_msg = fire; m_smi = smi; m_sci = sci; end
    endtask

    task automatic compare_all();
        check({cur_req, " rdata"}, int'(csr_rdata), int'(m_reg));
        check({cur_req, " msg"}, int'(err_msg_req), int'(m_msg));
        check({cur_req, " smi"}, int'(smi_req), int'(m_smi));
        check({cur_req, " sci"}, int'(sci_req), int'(m_sci));
        check({cur_req, " cfg"}, int'(therm_cfg_err), int'(n_routes() > 1));
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        hw_evt = '0; therm_trip = 0; csr_wr = 0; csr_wdata = '0; warm_rst = 0;
    endtask

    task automatic wr1c(input logic [15:0] d);
        csr_wr = 1; csr_wdata = d; cycle(); idle_inputs();
    endtask

    initial begin
        por_rst = 1; idle_inputs();
        err_global_en = 0; err_src_en = '0;
        therm_en_smi = 0; therm_en_sci = 0; therm_en_serr = 0;
        m_reg = '0; m_msg = 0; m_smi = 0; m_sci = 0;
        @(negedge clk);
        cycle(); cycle();
        cur_req = "R1";
        check("R1 reset rdata", int'(csr_rdata), 0);
        check("R1 reset msg", int'(err_msg_req | smi_req | sci_req), 0);
        por_rst = 0;
        cycle();

        cur_req = "R2";
        wr1c(16'hFFFF);
        check("R2 reserved after FFFF write", int'(csr_rdata), 0);

        cur_req = "R4";
        hw_evt = 4'b1111; cycle(); idle_inputs();
        check("R4 set without enables", int'(csr_rdata), 16'h6280);
        check("R4 no msg when disabled", int'(err_msg_req), 0);

        cur_req = "R3";
        wr1c(16'h0000);
        check("R3 zero write keeps", int'(csr_rdata), 16'h6280);
        wr1c(16'h2000);
        check("R3 clear bit13 only", int'(csr_rdata), 16'h4280);

        cur_req = "R5";
        err_global_en = 1; err_src_en = 4'b1111;
        hw_evt = 4'b0010; cycle(); idle_inputs();
        check("R5 msg pulse", int'(err_msg_req), 1);
        check("R5 flag visible", int'(csr_rdata[13]), 1);
        cycle();
        check("R5 pulse one cycle", int'(err_msg_req), 0);

        cur_req = "R6";
        hw_evt = 4'b0010; cycle(); idle_inputs();
        check("R6 no msg on set flag", int'(err_msg_req), 0);

        cur_req = "R7";
        wr1c(16'hFFFF);
        hw_evt = 4'b1111; cycle(); idle_inputs();
        check("R7 merged pulse", int'(err_msg_req), 1);
        cycle();
        check("R7 single pulse", int'(err_msg_req), 0);

        cur_req = "R11";
        wr1c(16'hFFFF);
        hw_evt = 4'b0100; csr_wr = 1; csr_wdata = 16'h0200; cycle(); idle_inputs();
        check("R11 set wins on clear flag", int'(csr_rdata[9]), 1);
        check("R11 msg kept", int'(err_msg_req), 1);
        hw_evt = 4'b0100; csr_wr = 1; csr_wdata = 16'h0200; cycle(); idle_inputs();
        check("R11 set wins on set flag", int'(csr_rdata[9]), 1);
        check("R11 no msg when already set", int'(err_msg_req), 0);

        cur_req = "R8";
        wr1c(16'hFFFF);
        therm_trip = 1; cycle(); idle_inputs();
        check("R8 no route no flag", int'(csr_rdata[11]), 0);
        therm_en_smi = 1; therm_trip = 1; cycle(); idle_inputs();
        check("R8 smi route", int'(smi_req), 1);
        check("R8 thermal flag", int'(csr_rdata[11]), 1);
        cur_req = "R12";
        therm_trip = 1; cycle(); idle_inputs();
        check("R12 no repeat smi", int'(smi_req), 0);
        cur_req = "R8";
        wr1c(16'h0800);
        therm_en_smi = 0; therm_en_sci = 1; therm_trip = 1; cycle(); idle_inputs();
        check("R8 sci route", int'(sci_req), 1);
        wr1c(16'h0800);
        therm_en_sci = 0; therm_en_serr = 1; err_global_en = 0;
        therm_trip = 1; cycle(); idle_inputs();
        check("R8 serr blocked by global", int'(csr_rdata[11]), 0);
        err_global_en = 1; therm_trip = 1; cycle(); idle_inputs();
        check("R8 serr route msg", int'(err_msg_req), 1);
        wr1c(16'h0800);

        cur_req = "R9";
        therm_en_smi = 1; therm_en_sci = 1; therm_en_serr = 0;
        cycle();
        check("R9 cfg error", int'(therm_cfg_err), 1);
        therm_trip = 1; cycle(); idle_inputs();
        check("R9 trip dropped", int'(csr_rdata[11] | smi_req | sci_req), 0);
        therm_en_sci = 0;

        cur_req = "R10";
        hw_evt = 4'b1000; warm_rst = 1; cycle(); idle_inputs();
        check("R10 flag kept", int'(csr_rdata), 16'h0080);
        check("R10 msg cleared", int'(err_msg_req), 0);
        warm_rst = 1; cycle(); idle_inputs();
        check("R10 warm keeps flags", int'(csr_rdata), 16'h0080);

        cur_req = "MIX";
        for (int n = 0; n < 400; n++) begin
            hw_evt = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
            therm_trip = ($urandom_range(0, 3) == 0);
            csr_wr = ($urandom_range(0, 2) == 0);
            csr_wdata = 16'($urandom);
            warm_rst = ($urandom_range(0, 19) == 0);
            err_global_en = ($urandom_range(0, 3) != 0);
            err_src_en = 4'($urandom);
            therm_en_smi = ($urandom_range(0, 2) == 0);
            therm_en_sci = ($urandom_range(0, 2) == 0);
            therm_en_serr = ($urandom_range(0, 2) == 0);
            cycle();
        end
        idle_inputs();
        cycle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule